// File: doc/BRIEF.md
# Mixed-Criticality Hardware Thread Scheduler

This block decides, on every clock cycle, which hardware thread of a fine-grained multithreaded pipeline may fetch next. It handles one to eight threads. Software marks each thread as either hard real-time or soft real-time. Hard threads receive cycles only through a cyclic table of reservation slots, so their rate does not depend on other threads. Soft threads share every other cycle under a rotating priority. A reserved slot whose owner is asleep, or whose owner is not marked hard, goes to the soft pool, so no cycle is wasted while a soft thread is ready.

The selection is registered. It appears on `sel_valid` and `sel_tid` one cycle after the clock edge that made it. A stall input freezes the whole decision state. Configuration writes land in shadow registers. They become active only when the slot walk wraps, so a hard thread's spacing stays intact for the period in progress. A plain round-robin mode, which ignores the classification and the table, is provided for comparison.

Top module: `mc_thread_sched`

## Requirements
- R1: While `rst_n` is low, `sel_valid` is 0 and `sel_tid` is 0. After reset the active table has every entry disabled, all threads are soft, and flexible mode is selected.
- R2: In flexible mode, on a non-stalled edge, the scheduler takes the first enabled slot entry at or after the slot pointer. If that entry names a thread (code 0 to 7) that exists, is marked hard and is active, that thread is selected and the soft-pool pointer does not move. The result shows on the outputs after that edge.
- R3: A slot entry holds code 8 (pool), code 9 to 14, a thread number at or above NUM_THREADS, a soft thread or a sleeping hard thread. Each such entry gives its cycle to the soft pool.
- R4: Entries with code 15 are skipped and consume no cycle. The pointer moves to the entry after the one used and returns to entry 0 after the last enabled entry. When no entry is enabled, every cycle is a pool cycle.
- R5: A pool cycle grants the first eligible thread at or after the rotating pointer, in circular order. The pointer then moves to the thread just after the grantee. In flexible mode the eligible threads are the active soft threads.
- R6: When a pool cycle finds no eligible thread, `sel_valid` is 0, `sel_tid` is 0, and the rotating pointer does not move.
- R7: While `stall` is high, the outputs, the slot pointer, the rotating pointer and the active configuration all hold.
- R8: In round-robin mode, every active thread is eligible in the pool regardless of class, and the slot table is not used.
- R9: Configuration writes use `cfg_sel` as follows:
  - 0: the slot table. Entry i is `cfg_wdata[4i+3:4i]`.
  - 1: the class mask. Bit i = 1 marks thread i hard.
  - 2: the mode. Bit 0 = 1 selects round-robin.
  - 3: ignored.

  A write first loads a shadow copy. The shadow becomes active on a non-stalled edge where the walk wraps, or on any non-stalled edge in round-robin mode. A value written on that same edge waits for the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| thread_active | input | NUM_THREADS | Per-thread ready (1) or sleeping (0) |
| stall | input | 1 | Freeze the scheduler |
| sel_valid | output | 1 | A thread is selected this cycle |
| sel_tid | output | 3 | Selected thread number |

## Verification
A slot pointer that is off by one entry misplaces a hard thread's grant within one period, which is at most eight issued cycles. A rotating pointer that points to the wrong thread shows as a soft thread out of turn on the next pool cycle. A configuration committed too early or too late changes the grant pattern from the first cycle of the wrong period. The reference model tracks pointers and shadow state independently and compares both outputs every cycle, so such faults appear within one table period of being created.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int TID_W     = 3;
  localparam int SLOT_N    = 8;
  localparam int SLOT_W    = 4;
  localparam int SLOT_IW   = 3;
  localparam int MAX_THR   = 8;
  localparam int CFG_DW    = SLOT_N * SLOT_W;

  localparam logic [SLOT_W-1:0] CODE_OFF = 4'hF;

  localparam logic [1:0] SEL_TABLE = 2'd0;
  localparam logic [1:0] SEL_CLASS = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;

  typedef logic [SLOT_W-1:0] slot_code_t;
endpackage

// File: rtl/hts_cfg_regs.sv
module hts_cfg_regs
  import hts_pkg::*;
#(
  parameter int NUM_THREADS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [CFG_DW-1:0]      wr_data,
  input  logic                   commit,
  output logic [CFG_DW-1:0]      tab_q,
  output logic [NUM_THREADS-1:0] hard_q,
  output logic                   rr_q
);
  logic [CFG_DW-1:0]      sh_tab_q, sh_tab_d;
  logic [NUM_THREADS-1:0] sh_hard_q, sh_hard_d;
  logic                   sh_rr_q, sh_rr_d;
  logic [CFG_DW-1:0]      tab_d;
  logic [NUM_THREADS-1:0] hard_d;
  logic                   rr_d;

  always_comb begin
    sh_tab_d  = sh_tab_q;
    sh_hard_d = sh_hard_q;
    sh_rr_d   = sh_rr_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_TABLE: sh_tab_d  = wr_data;
        SEL_CLASS: sh_hard_d = wr_data[NUM_THREADS-1:0];
        SEL_MODE:  sh_rr_d   = wr_data[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    tab_d  = tab_q;
    hard_d = hard_q;
    rr_d   = rr_q;
    if (commit) begin
      tab_d  = sh_tab_q;
      hard_d = sh_hard_q;
      rr_d   = sh_rr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tab_q  <= '1;
      sh_hard_q <= '0;
      sh_rr_q   <= 1'b0;
      tab_q     <= '1;
      hard_q    <= '0;
      rr_q      <= 1'b0;
    end else begin
      sh_tab_q  <= sh_tab_d;
      sh_hard_q <= sh_hard_d;
      sh_rr_q   <= sh_rr_d;
      tab_q     <= tab_d;
      hard_q    <= hard_d;
      rr_q      <= rr_d;
    end
  end
endmodule

// File: rtl/hts_slot_walker.sv
module hts_slot_walker
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              rr_mode,
  input  logic [CFG_DW-1:0] tab,
  output logic              found,
  output slot_code_t        used_code,
  output logic              wrap
);
  logic [SLOT_IW-1:0] ptr_q, ptr_d;
  logic [SLOT_N-1:0]  en;
  logic [SLOT_IW-1:0] used_idx;
  logic               later;

  for (genvar g = 0; g < SLOT_N; g++) begin : g_en
    assign en[g] = (tab[g*SLOT_W +: SLOT_W] != CODE_OFF);
  end

  always_comb begin
    found    = 1'b0;
    used_idx = '0;
    for (int k = 0; k < SLOT_N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % SLOT_N;
      if (!found && en[idx]) begin
        found    = 1'b1;
        used_idx = SLOT_IW'(idx);
      end
    end
    if (rr_mode) found = 1'b0;
  end

  always_comb begin
    later = 1'b0;
    for (int j = 0; j < SLOT_N; j++) begin
      if (j > int'(used_idx) && en[j]) later = 1'b1;
    end
  end

  assign used_code = tab[used_idx*SLOT_W +: SLOT_W];
  assign wrap      = !found || !later;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = wrap ? '0 : used_idx + SLOT_IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/hts_rr_pool.sv
module hts_rr_pool
  import hts_pkg::*;
#(
  parameter int NUM_THREADS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   take,
  input  logic [NUM_THREADS-1:0] elig,
  output logic                   gnt_valid,
  output logic [TID_W-1:0]       gnt_tid
);
  localparam int PW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

  logic [PW-1:0] rr_q, rr_d;
  int            gnt_i;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_i     = 0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % NUM_THREADS;
      if (!gnt_valid && elig[idx]) begin
        gnt_valid = 1'b1;
        gnt_i     = idx;
      end
    end
  end

  assign gnt_tid = TID_W'(gnt_i);

  always_comb begin
    rr_d = rr_q;
    if (adv && take && gnt_valid)
      rr_d = (gnt_i == NUM_THREADS - 1) ? '0 : PW'(gnt_i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/mc_thread_sched.sv
module mc_thread_sched
  import hts_pkg::*;
#(
  parameter int NUM_THREADS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [31:0]              cfg_wdata,
  input  logic [NUM_THREADS-1:0]   thread_active,
  input  logic                     stall,
  output logic                     sel_valid,
  output logic [2:0]               sel_tid
);
  logic                   adv;
  logic                   commit;
  logic [CFG_DW-1:0]      tab;
  logic [NUM_THREADS-1:0] hard;
  logic                   rr_mode;
  logic                   found;
  slot_code_t             used_code;
  logic                   wrap;
  logic [MAX_THR-1:0]     hard8, act8;
  logic                   hard_hit;
  logic [NUM_THREADS-1:0] elig;
  logic                   gnt_valid;
  logic [TID_W-1:0]       gnt_tid;
  logic                   valid_d;
  logic [TID_W-1:0]       tid_d;

  assign adv    = !stall;
  assign commit = adv && (wrap || rr_mode);

  hts_cfg_regs #(.NUM_THREADS(NUM_THREADS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .commit  (commit),
    .tab_q   (tab),
    .hard_q  (hard),
    .rr_q    (rr_mode)
  );

  hts_slot_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .rr_mode   (rr_mode),
    .tab       (tab),
    .found     (found),
    .used_code (used_code),
    .wrap      (wrap)
  );

  always_comb begin
    hard8 = '0;
    act8  = '0;
    hard8[NUM_THREADS-1:0] = hard;
    act8[NUM_THREADS-1:0]  = thread_active;
  end

  assign hard_hit = found && !used_code[SLOT_W-1]
                    && hard8[used_code[TID_W-1:0]]
                    && act8[used_code[TID_W-1:0]];

  assign elig = rr_mode ? thread_active : (thread_active & ~hard);

  hts_rr_pool #(.NUM_THREADS(NUM_THREADS)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .take      (!hard_hit),
    .elig      (elig),
    .gnt_valid (gnt_valid),
    .gnt_tid   (gnt_tid)
  );

  always_comb begin
    valid_d = sel_valid;
    tid_d   = sel_tid;
    if (adv) begin
      valid_d = hard_hit || gnt_valid;
      tid_d   = hard_hit ? used_code[TID_W-1:0] : gnt_tid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_tid   <= '0;
    end else begin
      sel_valid <= valid_d;
      sel_tid   <= tid_d;
    end
  end
endmodule

// File: rtl/hts_checker.sv
module hts_checker
  import hts_pkg::*;
#(
  parameter int NUM_THREADS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stall,
  input logic [NUM_THREADS-1:0] thread_active,
  input logic                   sel_valid,
  input logic [2:0]             sel_tid,
  input logic                   hard_hit,
  input slot_code_t             used_code,
  input logic                   commit,
  input logic [NUM_THREADS-1:0] hard,
  input logic                   rr_mode
);
  logic [MAX_THR-1:0] act_prev;
  logic [MAX_THR-1:0] act8;

  always_comb begin
    act8 = '0;
    act8[NUM_THREADS-1:0] = thread_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= '0;
    else        act_prev <= act8;
  end

  assert_hard_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && hard_hit) |=> (sel_valid && sel_tid == $past(used_code[2:0])));

  assert_grant_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (!sel_valid || act_prev[sel_tid]));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && thread_active == '0) |=> !sel_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(sel_valid) && $stable(sel_tid)));

  assert_tid_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (int'(sel_tid) < NUM_THREADS));

  assert_commit_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hard) || !$stable(rr_mode)) |-> $past(commit));
endmodule

bind mc_thread_sched hts_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .thread_active (thread_active),
  .sel_valid     (sel_valid),
  .sel_tid       (sel_tid),
  .hard_hit      (hard_hit),
  .used_code     (used_code),
  .commit        (commit),
  .hard          (hard),
  .rr_mode       (rr_mode)
);

// File: tb/mc_thread_sched_test.sv
`timescale 1ns/1ps
module mc_thread_sched_test;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NT-1:0] thread_active = '0;
  logic          stall = 1'b0;
  logic          sel_valid;
  logic [2:0]    sel_tid;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  mc_thread_sched #(.NUM_THREADS(NT)) uut (.*);

  // behavioural reference model
  int m_tab[8], sh_tab[8];
  bit [NT-1:0] m_hard, sh_hard;
  bit m_rr, sh_rr;
  int m_ptr, m_rrp;
  bit exp_v;
  int exp_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_tab[i]) begin m_tab[i] = 15; sh_tab[i] = 15; end
      m_hard = '0; sh_hard = '0; m_rr = 0; sh_rr = 0;
      m_ptr = 0; m_rrp = 0; exp_v = 0; exp_t = 0;
    end else begin
      if (!stall) begin
        int used, code, g;
        bit hit, wrp;
        used = -1; hit = 0; wrp = 1; code = 0; g = -1;
        if (!m_rr)
          for (int k = 0; k < 8; k++)
            if (used < 0 && m_tab[(m_ptr + k) % 8] != 15) used = (m_ptr + k) % 8;
        if (used >= 0) begin
          for (int j = used + 1; j < 8; j++) if (m_tab[j] != 15) wrp = 0;
          code = m_tab[used];
          if (code < NT) hit = m_hard[code] && thread_active[code];
        end
        if (hit) begin
          exp_v = 1; exp_t = code;
        end else begin
          for (int k = 0; k < NT; k++) begin
            int ix;
            ix = (m_rrp + k) % NT;
            if (g < 0 && thread_active[ix] && (m_rr || !m_hard[ix])) g = ix;
          end
          if (g >= 0) begin exp_v = 1; exp_t = g; m_rrp = (g + 1) % NT; end
          else begin exp_v = 0; exp_t = 0; end
        end
        m_ptr = wrp ? 0 : used + 1;
        if (wrp) begin
          m_tab = sh_tab; m_hard = sh_hard; m_rr = sh_rr;
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: for (int i = 0; i < 8; i++) sh_tab[i] = int'(cfg_wdata[4*i +: 4]);
          2'd1: sh_hard = cfg_wdata[NT-1:0];
          2'd2: sh_rr = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input bit v, input int t);
    checks++;
    if (sel_valid !== v || int'(sel_tid) != t) begin
      fails++;
      $display("FAIL %s valid=%0b tid=%0d expected valid=%0b tid=%0d at %0t",
               req, sel_valid, sel_tid, v, t, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) chk(cur_req, exp_v, exp_t);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(3);
    chk("R1", 0, 0);
    rst_n = 1;
    // R5: empty table, all soft, rotating grant
    cur_req = "R5"; thread_active = 4'b1111; step(10);
    thread_active = 4'b1010; step(6);
    // R6: nobody ready
    cur_req = "R6"; thread_active = 4'b0000; step(4);
    @(negedge clk); chk("R6", 0, 0);
    // R2/R3/R4: table 0,8,off,2,5,off,off,off; thread 0 hard
    cur_req = "R9"; thread_active = 4'b1111;
    wr(2'd1, 32'h1);
    wr(2'd0, 32'hFFF5_2F80);
    cur_req = "R2"; step(20);
    cur_req = "R3"; thread_active = 4'b1110; step(10);
    thread_active = 4'b0001; step(10);
    // R4: all entries disabled except last
    cur_req = "R4"; thread_active = 4'b1111;
    wr(2'd0, 32'h0FFF_FFFF); step(12);
    wr(2'd0, 32'h0F0F_1F0F); wr(2'd1, 32'h3); step(16);
    // R7: stall bursts
    cur_req = "R7";
    for (int i = 0; i < 30; i++) begin
      stall = (i % 3) != 0; step(1);
    end
    stall = 0;
    // R8: round-robin mode ignores class
    cur_req = "R8"; wr(2'd2, 32'h1); step(12);
    thread_active = 4'b0101; step(8);
    wr(2'd2, 32'h0); step(8);
    // R9: mid-period writes, random mix
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      thread_active = NT'($urandom);
      stall = ($urandom % 5) == 0;
      cfg_we = ($urandom % 9) == 0;
      cfg_sel = 2'($urandom);
      begin
        logic [31:0] d;
        for (int e = 0; e < 8; e++) begin
          int r;
          r = $urandom % 10;
          d[4*e +: 4] = (r < 8) ? 4'(r) : (r == 8 ? 4'd8 : 4'd15);
        end
        if (cfg_sel == 2'd2) d[0] = ($urandom % 4) == 0;
        cfg_wdata = d;
      end
    end
    @(negedge clk); cfg_we = 0; stall = 0; step(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule